// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a small bank of 16-bit configuration registers that a host reaches through two ports: an address port that holds a register index, and a data port that reads or writes the register the index selects. Locations 0 and 1 change meaning with an operating-mode input. In master mode they hold two 4-bit command-timing values. In slave mode location 1 becomes a pointer into a local SRAM, and location 0 becomes a window onto that SRAM: each access through it goes to the location the pointer names, and the pointer then moves on by one for a byte access or by two for a word access.

Host requests arrive on a valid/ready channel. `req_ready` is always high, so the block never applies back-pressure and a request is taken on every clock edge where `req_valid` is high. Every accepted read gets exactly one response, marked by a one-cycle `rsp_valid` pulse, and writes get none. The host cannot stall the response, so it must take `rsp_rdata` in the cycle where `rsp_valid` is high. The SRAM sits outside the block. It sees a request strobe during the host's request cycle and returns read data on the following edge.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the index is 0 and the data port reads 0005h at locations 0 and 1, 0002h at 2, 0084h at 5, 0008h at 6, 0090h at 7, and 0000h at 3, 4, 8 and 9. After reset `rsp_valid`, `access_err` and `sram_req` are low and `req_ready` is high.
- R2: A write to the address port (`req_data_port`=0) stores `req_wdata[7:0]` as the index, ignoring `req_be`. A read of the address port returns the index, zero-extended.
- R3: In master mode (`slave_mode`=0), locations 0 and 1 store only bits 3:0 of a data-port write, and they read back with bits 15:4 at zero.
- R4: Locations 2 to 9 are full 16-bit registers. Byte lanes are given by `req_be`: 11 selects a word and 01 selects the low byte. A low-byte write changes only bits 7:0, and a low-byte read returns bits 7:0 with the upper byte at zero.
- R5: A data-port read at an index of 10 or more returns 0000h, and a data-port write there changes no register.
- R6: In slave mode, a data-port write at location 0 drives `sram_req`=1, `sram_we`=1, `sram_addr`=pointer, `sram_wdata`=`req_wdata` and `sram_be`=`req_be` in the cycle the request is presented.
- R7: In slave mode, a data-port read at location 0 reads the SRAM at the pointer. A word read returns the SRAM word, and a low-byte read returns its bits 7:0 zero-extended.
- R8: Each accepted slave-mode access at location 0 adds 2 to the pointer for a word access and 1 for a byte access, wrapping modulo 2^16.
- R9: A data-port access with `req_be` of 10 (odd byte) or 00 is ignored. It writes no register and no SRAM, does not move the pointer, and a read returns 0000h. `access_err` is high for exactly the one cycle after acceptance.
- R10: In slave mode, location 1 reads and writes the pointer (a low-byte write replaces bits 7:0 only). A written value addresses the next location-0 access, and the pointer holds its value when nothing accesses it.
- R11: Each accepted read produces `rsp_valid` and its data in the cycle after acceptance. Writes produce no response.
- R12: The master-mode timing values are kept unchanged while the block is in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: slave mode with the SRAM window; 0: master mode with the timing registers |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request ready; always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_port | input | 1 | 1 = data port, 0 = address port |
| req_be | input | 2 | Byte lanes: 11 word, 01 low byte, others illegal on the data port |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_rdata | output | 16 | Read response data |
| access_err | output | 1 | One-cycle pulse after an illegal data-port access |
| sram_req | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write enable |
| sram_be | output | 2 | SRAM byte lanes |
| sram_addr | output | 16 | SRAM address (the pointer) |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, valid on the edge after `sram_req` |

## Verification
The SRAM strobe and its address, data and lanes are combinational and due in the same cycle as the request. The bench inputs change on the falling edge and are stable by the next rising edge, and the bench samples the strobe 1 ns after it drives the request. Read responses, the error pulse and pointer changes all land on the rising edge that accepts the request. The scoreboard monitor compares responses on the falling edge that follows that rising edge, and the error pulse is checked 1 ns after the accepting edge and again one cycle later. Effects on the pointer and the SRAM are seen through later reads of location 1 and of the window.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_INDEX,
    ACC_REG,
    ACC_TIMING,
    ACC_SRAM_DATA,
    ACC_SRAM_PTR,
    ACC_REJECT,
    ACC_VOID
  } acc_kind_e;

  localparam logic [1:0] BE_WORD = 2'b11;
  localparam logic [1:0] BE_LOW  = 2'b01;

  // Power-up contents of each location.
  function automatic logic [15:0] reset_value(input int slot);
    case (slot)
      0, 1:    return 16'h0005;
      2:       return 16'h0002;
      5:       return 16'h0084;
      6:       return 16'h0008;
      7:       return 16'h0090;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int NUM_REGS   = 10,
  parameter int NUM_TIMING = 2
) (
  input  logic             fire,
  input  logic             data_port,
  input  logic             slave_mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       be,
  output acc_kind_e        kind,
  output logic             byte_acc
);

  localparam logic [IDX_W-1:0] LIMIT   = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] TIM_END = IDX_W'(NUM_TIMING);

  logic lanes_ok;

  always_comb begin
    lanes_ok = (be == BE_WORD) || (be == BE_LOW);
    byte_acc = (be == BE_LOW);
    kind     = ACC_NONE;
    if (fire) begin
      if (!data_port)           kind = ACC_INDEX;
      else if (!lanes_ok)       kind = ACC_REJECT;
      else if (idx >= LIMIT)    kind = ACC_VOID;
      else if (idx < TIM_END) begin
        if (slave_mode)         kind = (idx == '0) ? ACC_SRAM_DATA : ACC_SRAM_PTR;
        else                    kind = ACC_TIMING;
      end
      else                      kind = ACC_REG;
    end
  end

endmodule

// File: rtl/cfgp_reg_bank.sv
module cfgp_reg_bank
  import cfgp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 8,
  parameter int NUM_REGS   = 10,
  parameter int NUM_TIMING = 2,
  parameter int TIMING_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_low,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);

  localparam int BYTE_W = 8;

  logic [DATA_W-1:0] slot [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    localparam logic [DATA_W-1:0] RST = DATA_W'(reset_value(g));
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(g));

    if (g < NUM_TIMING) begin : g_timing
      logic [TIMING_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST[TIMING_W-1:0];
        else if (hit) q <= wdata[TIMING_W-1:0];
      end
      assign slot[g] = {{(DATA_W-TIMING_W){1'b0}}, q};
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST;
        else if (hit) q <= wr_low ? {q[DATA_W-1:BYTE_W], wdata[BYTE_W-1:0]} : wdata;
      end
      assign slot[g] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rd_data = slot[i];
  end

  // R5: the bank is never written at an index outside the populated range
  p_bank_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (idx < IDX_W'(NUM_REGS)));

endmodule

// File: rtl/cfgp_sram_window.sv
module cfgp_sram_window #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_write,
  input  logic              acc_byte,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ptr_wr,
  input  logic              ptr_low,
  output logic [PTR_W-1:0]  ptr,
  output logic              sram_req,
  output logic              sram_we,
  output logic [1:0]        sram_be,
  output logic [PTR_W-1:0]  sram_addr,
  output logic [DATA_W-1:0] sram_wdata
);

  localparam int             BYTE_W    = 8;
  localparam logic [PTR_W-1:0] STEP_BYTE = PTR_W'(1);
  localparam logic [PTR_W-1:0] STEP_WORD = PTR_W'(2);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] load_val;

  assign load_val = PTR_W'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_wr) ptr_q <= ptr_low ? {ptr_q[PTR_W-1:BYTE_W], load_val[BYTE_W-1:0]} : load_val;
    else if (acc)    ptr_q <= ptr_q + (acc_byte ? STEP_BYTE : STEP_WORD);
  end

  assign ptr        = ptr_q;
  assign sram_req   = acc;
  assign sram_we    = acc && acc_write;
  assign sram_be    = acc_byte ? 2'b01 : 2'b11;
  assign sram_addr  = ptr_q;
  assign sram_wdata = wdata;

  // R8: word access advances by two, byte access by one, modulo 2^PTR_W
  p_ptr_word_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_byte) |=> (ptr_q == $past(ptr_q) + STEP_WORD));
  p_ptr_byte_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_byte) |=> (ptr_q == $past(ptr_q) + STEP_BYTE));
  // R10: a full pointer write lands as given; an idle pointer holds
  p_ptr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && !ptr_low) |=> (ptr_q == $past(load_val)));
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !ptr_wr) |=> $stable(ptr_q));
  // R6: window access and pointer load never coincide
  p_one_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && ptr_wr));

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 8,
  parameter int NUM_REGS   = 10,
  parameter int NUM_TIMING = 2,
  parameter int TIMING_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_data_port,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              access_err,
  output logic              sram_req,
  output logic              sram_we,
  output logic [1:0]        sram_be,
  output logic [DATA_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata
);

  localparam int BYTE_W = 8;
  localparam int PTR_W  = DATA_W;

  logic              fire;
  logic [IDX_W-1:0]  idx_q;
  acc_kind_e         kind;
  logic              byte_acc;
  logic [DATA_W-1:0] bank_rd;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] rd_next;

  logic              rsp_valid_q;
  logic              rsp_sram_q;
  logic              rsp_byte_q;
  logic [DATA_W-1:0] rsp_reg_q;
  logic              err_q;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;

  cfgp_decode #(
    .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .NUM_TIMING(NUM_TIMING)
  ) u_decode (
    .fire       (fire),
    .data_port  (req_data_port),
    .slave_mode (slave_mode),
    .idx        (idx_q),
    .be         (req_be),
    .kind       (kind),
    .byte_acc   (byte_acc)
  );

  cfgp_reg_bank #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS),
    .NUM_TIMING(NUM_TIMING), .TIMING_W(TIMING_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_write && (kind == ACC_REG || kind == ACC_TIMING)),
    .wr_low  (byte_acc),
    .idx     (idx_q),
    .wdata   (req_wdata),
    .rd_data (bank_rd)
  );

  cfgp_sram_window #(
    .PTR_W(PTR_W), .DATA_W(DATA_W)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (kind == ACC_SRAM_DATA),
    .acc_write  (req_write),
    .acc_byte   (byte_acc),
    .wdata      (req_wdata),
    .ptr_wr     (req_write && kind == ACC_SRAM_PTR),
    .ptr_low    (byte_acc),
    .ptr        (ptr),
    .sram_req   (sram_req),
    .sram_we    (sram_we),
    .sram_be    (sram_be),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata)
  );

  // Index register behind the address port.
  always_ff @(posedge clk) begin
    if (!rst_n)                            idx_q <= '0;
    else if (kind == ACC_INDEX && req_write) idx_q <= req_wdata[IDX_W-1:0];
  end

  // Register-side read data, with byte masking on data-port reads.
  always_comb begin
    case (kind)
      ACC_INDEX:              rd_next = DATA_W'(idx_q);
      ACC_REG, ACC_TIMING:    rd_next = bank_rd;
      ACC_SRAM_PTR:           rd_next = DATA_W'(ptr);
      default:                rd_next = '0;
    endcase
    if (kind != ACC_INDEX && byte_acc)
      rd_next = {{(DATA_W-BYTE_W){1'b0}}, rd_next[BYTE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_sram_q  <= 1'b0;
      rsp_byte_q  <= 1'b0;
      rsp_reg_q   <= '0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= fire && !req_write;
      rsp_sram_q  <= (kind == ACC_SRAM_DATA);
      rsp_byte_q  <= byte_acc;
      rsp_reg_q   <= rd_next;
      err_q       <= (kind == ACC_REJECT);
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign access_err = err_q;
  assign rsp_rdata  = !rsp_sram_q ? rsp_reg_q :
                      rsp_byte_q  ? {{(DATA_W-BYTE_W){1'b0}}, sram_rdata[BYTE_W-1:0]} :
                                    sram_rdata;

  // R11: one response per accepted read, none for a write
  p_read_answers_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write) |=> rsp_valid);
  p_write_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write) |=> !rsp_valid);
  // R9: a rejected access never reaches the SRAM and raises the error next cycle
  p_reject_no_sram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_REJECT) |-> !sram_req);
  p_reject_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_REJECT) |=> (access_err && $stable(ptr)));
  // R5: a read of an unpopulated index answers zero
  p_void_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_VOID && !req_write) |=> (rsp_rdata == '0));
  // R12: timing locations are never written while in slave mode
  p_timing_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (kind != ACC_TIMING));

endmodule

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_data_port = 1'b0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        access_err;
  logic        sram_req, sram_we;
  logic [1:0]  sram_be;
  logic [15:0] sram_addr, sram_wdata;
  logic [15:0] sram_rdata = '0;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [15:0] d; string tag; } exp_t;
  exp_t sb_q[$];

  // Snapshot of the SRAM strobe taken during the last request cycle.
  logic        s_req, s_we;
  logic [1:0]  s_be;
  logic [15:0] s_addr, s_wdata;

  always #(CLK_NS/2) clk = ~clk;

  cfg_index_port dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_data_port(req_data_port), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .access_err(access_err),
    .sram_req(sram_req), .sram_we(sram_we), .sram_be(sram_be),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  // Synchronous SRAM model.
  logic [15:0] mem [int];
  always @(posedge clk) begin
    if (sram_req) begin
      if (sram_we) begin
        logic [15:0] old;
        old = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0000;
        if (sram_be[1]) old[15:8] = sram_wdata[15:8];
        if (sram_be[0]) old[7:0]  = sram_wdata[7:0];
        mem[int'(sram_addr)] = old;
      end else begin
        sram_rdata <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0000;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected responses as the design produces them.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) check("R11 unexpected response", 16'h0001, 16'h0000);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rsp_rdata, e.d);
      end
    end
  end

  // Driver: one request per call; reads push their expected data.
  task automatic xfer(input bit wr, input bit dp, input logic [1:0] be,
                      input logic [15:0] wd, input logic [15:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_data_port = dp; req_be = be; req_wdata = wd;
    if (!wr) sb_q.push_back('{exp, tag});
    #1;
    s_req = sram_req; s_we = sram_we; s_be = sram_be; s_addr = sram_addr; s_wdata = sram_wdata;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic set_idx(input logic [15:0] i);
    xfer(1'b1, 1'b0, 2'b11, i, 16'h0, "");
  endtask

  task automatic wr_reg(input logic [15:0] i, input logic [1:0] be, input logic [15:0] d);
    set_idx(i);
    xfer(1'b1, 1'b1, be, d, 16'h0, "");
  endtask

  task automatic rd_reg(input logic [15:0] i, input logic [1:0] be,
                        input logic [15:0] exp, input string tag);
    set_idx(i);
    xfer(1'b0, 1'b1, be, 16'h0, exp, tag);
  endtask

  function automatic logic [15:0] expect_default(input int i);
    case (i)
      0: return 16'h0005;  1: return 16'h0005;  2: return 16'h0002;
      5: return 16'h0084;  6: return 16'h0008;  7: return 16'h0090;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rsp_valid in reset", {15'b0, rsp_valid}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {15'b0, rsp_valid}, 16'h0);
    check("R1 access_err after reset", {15'b0, access_err}, 16'h0);
    check("R1 sram_req after reset", {15'b0, sram_req}, 16'h0);
    check("R1 req_ready", {15'b0, req_ready}, 16'h1);

    // R1 / R2: index starts at 0, then every default
    xfer(1'b0, 1'b0, 2'b11, 16'h0, 16'h0000, "R2 index reset read");
    for (int i = 0; i < 10; i++)
      rd_reg(16'(i), 2'b11, expect_default(i), $sformatf("R1 default idx %0d", i));
    xfer(1'b0, 1'b0, 2'b01, 16'h0, 16'h0009, "R2 index readback");

    // R3: master timing locations keep 4 bits
    wr_reg(16'h0, 2'b11, 16'hFFFF);
    rd_reg(16'h0, 2'b11, 16'h000F, "R3 timing0 masked");
    wr_reg(16'h1, 2'b11, 16'h1233);
    rd_reg(16'h1, 2'b11, 16'h0003, "R3 timing1 masked");

    // R4: plain registers, byte lanes
    wr_reg(16'h4, 2'b11, 16'hA5C3);
    rd_reg(16'h4, 2'b11, 16'hA5C3, "R4 word write");
    wr_reg(16'h4, 2'b01, 16'h12FF);
    rd_reg(16'h4, 2'b11, 16'hA5FF, "R4 low byte write");
    rd_reg(16'h4, 2'b01, 16'h00FF, "R4 low byte read");
    wr_reg(16'h9, 2'b11, 16'h0BAD);
    rd_reg(16'h9, 2'b11, 16'h0BAD, "R4 last location");

    // R5: unpopulated indexes
    wr_reg(16'h0C, 2'b11, 16'h1234);
    rd_reg(16'h0C, 2'b11, 16'h0000, "R5 idx 0C reads zero");
    wr_reg(16'h0A, 2'b11, 16'h4321);
    rd_reg(16'h0A, 2'b11, 16'h0000, "R5 idx 0A reads zero");
    rd_reg(16'h4, 2'b11, 16'hA5FF, "R5 no alias into idx 4");
    rd_reg(16'h2, 2'b11, 16'h0002, "R5 no alias into idx 2");

    // Slave mode
    @(negedge clk); slave_mode = 1'b1;
    rd_reg(16'h1, 2'b11, 16'h0000, "R10 pointer reset");
    wr_reg(16'h1, 2'b11, 16'h0010);
    rd_reg(16'h1, 2'b11, 16'h0010, "R10 pointer write");

    set_idx(16'h0);
    xfer(1'b1, 1'b1, 2'b11, 16'hBEEF, 16'h0, "");
    check("R6 sram_req", {15'b0, s_req}, 16'h1);
    check("R6 sram_we", {15'b0, s_we}, 16'h1);
    check("R6 sram_addr", s_addr, 16'h0010);
    check("R6 sram_wdata", s_wdata, 16'hBEEF);
    check("R6 sram_be word", {14'b0, s_be}, 16'h0003);
    rd_reg(16'h1, 2'b11, 16'h0012, "R8 word step");

    set_idx(16'h0);
    xfer(1'b1, 1'b1, 2'b01, 16'h9977, 16'h0, "");
    check("R6 sram_be byte", {14'b0, s_be}, 16'h0001);
    check("R6 sram_addr byte", s_addr, 16'h0012);
    rd_reg(16'h1, 2'b11, 16'h0013, "R8 byte step");

    wr_reg(16'h1, 2'b11, 16'h0010);
    set_idx(16'h0);
    xfer(1'b0, 1'b1, 2'b11, 16'h0, 16'hBEEF, "R7 word read");
    check("R7 read strobe no we", {15'b0, s_we}, 16'h0);
    xfer(1'b0, 1'b1, 2'b01, 16'h0, 16'h0077, "R7 byte read");
    xfer(1'b0, 1'b1, 2'b11, 16'h0, 16'h0000, "R7 unwritten word");
    rd_reg(16'h1, 2'b11, 16'h0015, "R8 mixed steps");

    // R9: illegal lanes
    set_idx(16'h0);
    xfer(1'b1, 1'b1, 2'b10, 16'h5555, 16'h0, "");
    check("R9 no sram strobe", {15'b0, s_req}, 16'h0);
    check("R9 error pulse", {15'b0, access_err}, 16'h1);
    @(posedge clk); #1;
    check("R9 error one cycle", {15'b0, access_err}, 16'h0);
    xfer(1'b0, 1'b1, 2'b00, 16'h0, 16'h0000, "R9 illegal read zero");
    check("R9 error pulse read", {15'b0, access_err}, 16'h1);
    rd_reg(16'h1, 2'b11, 16'h0015, "R9 pointer unmoved");
    wr_reg(16'h4, 2'b10, 16'hFFFF);
    rd_reg(16'h4, 2'b11, 16'hA5FF, "R9 register unchanged");
    wr_reg(16'h1, 2'b11, 16'h0012);
    set_idx(16'h0);
    xfer(1'b0, 1'b1, 2'b11, 16'h0, 16'h0077, "R9 sram untouched");

    // R8 wrap
    wr_reg(16'h1, 2'b11, 16'hFFFF);
    wr_reg(16'h0, 2'b01, 16'h0011);
    rd_reg(16'h1, 2'b11, 16'h0000, "R8 byte wrap");
    wr_reg(16'h1, 2'b11, 16'hFFFE);
    wr_reg(16'h0, 2'b11, 16'h2222);
    rd_reg(16'h1, 2'b11, 16'h0000, "R8 word wrap");

    // R10: low-byte pointer write
    wr_reg(16'h1, 2'b11, 16'h1234);
    wr_reg(16'h1, 2'b01, 16'hFFAB);
    rd_reg(16'h1, 2'b11, 16'h12AB, "R10 low byte pointer write");
    rd_reg(16'h1, 2'b01, 16'h00AB, "R10 low byte pointer read");

    // R11: a write draws no response
    xfer(1'b1, 1'b0, 2'b11, 16'h0003, 16'h0, "");
    @(negedge clk);
    check("R11 no response after write", {15'b0, rsp_valid}, 16'h0);

    // R12: timing values survive slave mode
    slave_mode = 1'b0;
    rd_reg(16'h0, 2'b11, 16'h000F, "R12 timing0 retained");
    rd_reg(16'h1, 2'b11, 16'h0003, "R12 timing1 retained");

    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", 16'(sb_q.size()), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule